// File: doc/BRIEF.md
# Coprocessor Boot and Remap Controller

This block sits on an add-in card that carries a guest processor behind a host bus. It keeps the guest in reset from power-up, gives the host a window onto a dual-ported shared memory, and holds a host-writable page table. The table steers every guest access to private RAM or to the shared memory, or rejects it. The host places a boot program in shared memory, which the table maps at guest page zero out of reset. It then lets the guest run, and the guest copies that program into private RAM.

To finish booting, the host puts the guest back in reset and rewrites entry zero of the table so that page zero points at the private copy. That copy then serves as the guest's ROM. The host then releases the guest again. The shared memory stays mapped afterwards, and the two processors pass work and results through it.

The host sees a 16 MB window. The top two address bits pick a region: 00 is shared memory, 10 is the page table, 11 is the control word, and 01 is unused. The guest's 16 MB space is split into 64 pages of 256 KB, and address bits 23:18 select the page. Within any mapped target, bits 7:2 select the word.

Top module: `cbc_boot_ctrl`

## Requirements
- R1: After reset `g_rst_n` is low and the control word reads 0x1 (bit0 = hold, bit1 = lock error).
- R2: After reset, table entry 0 reads 2 (shared) and every other entry reads 0 (unmapped). Table entry n is at host address 0x800000 + 4n, and its code is in data bits 1:0.
- R3: A host write to shared-memory word k (host address 4k) is returned by a host read of the same address. Read data appears in the cycle after the read request.
- R4: While hold is set, guest requests get no acknowledge or bus error and write nothing. A host write of 0 to the control word (address 0xC00000) raises `g_rst_n` in the cycle after the write.
- R5: A running guest access to a page coded 1 (private RAM) or 2 (shared) is acknowledged one cycle later. Read data arrives with the acknowledge, and guest writes to shared memory are visible to host reads.
- R6: A running guest access to a page coded 0 or 3 raises `g_berr` for one cycle with `g_rdata` = 0 and no acknowledge.
- R7: A host table write while the guest runs leaves the table unchanged and sets the sticky lock-error bit. A control write with bit1 = 1 clears that bit.
- R8: After the host rewrites entry 0 to code 1 during a hold, a guest read of page 0 returns private-RAM contents.
- R9: Writing 1 to control bit0 lowers `g_rst_n` again and leaves the table contents unchanged.
- R10: When the host and the guest write the same shared word in the same cycle, the host value is kept. A guest read that coincides with a host write returns the old value, and the next guest read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_sel | input | 1 | Host access strobe |
| h_we | input | 1 | Host write enable |
| h_addr | input | 24 | Host byte address within the card window |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid the cycle after the read |
| g_rst_n | output | 1 | Guest reset, active low |
| g_req | input | 1 | Guest access strobe |
| g_we | input | 1 | Guest write enable |
| g_addr | input | 24 | Guest byte address |
| g_wdata | input | 32 | Guest write data |
| g_rdata | output | 32 | Guest read data, zero unless a read is acknowledged |
| g_ack | output | 1 | Guest access completed |
| g_berr | output | 1 | Guest access hit an unmapped or reserved page |

## Verification
The bench first confirms that a held guest cannot write shared memory. A decoder that forgot the hold would let that stray write through, and the host would read it back. It then tries a table write while the guest runs. A design without the lock would retarget page zero under the running guest, and the following guest read would return private data instead of shared data. It also checks that a remap made during a second hold takes effect and that the other entries survive the re-hold. A table cleared on that hold would turn page 1 into a bus error. Finally, it drives host and guest into the same shared word in the same cycle. Wrong port priority shows up as the guest's value surviving, and a bypassed read shows up as the new value one cycle early.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_PRIV   = 2'd1,
    TGT_SHARED = 2'd2,
    TGT_RSVD   = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    HR_SHARED = 2'd0,
    HR_NONE   = 2'd1,
    HR_TABLE  = 2'd2,
    HR_CTRL   = 2'd3
  } hreg_e;
endpackage

// File: rtl/cbc_decode_table.sv
module cbc_decode_table
  import cbc_pkg::*;
#(
  parameter int PAGE_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PAGE_BITS-1:0] wr_idx,
  input  tgt_e                 wr_code,
  input  logic [PAGE_BITS-1:0] rd_idx,
  output tgt_e                 rd_code,
  input  logic [PAGE_BITS-1:0] lk_idx,
  output tgt_e                 lk_code
);
  localparam int NPAGES = 1 << PAGE_BITS;

  tgt_e tbl_q [NPAGES];
  tgt_e tbl_d [NPAGES];

  for (genvar i = 0; i < NPAGES; i++) begin : g_entry
    localparam tgt_e RST_CODE = (i == 0) ? TGT_SHARED : TGT_NONE;
    logic hit;
    assign hit      = wr_en && (wr_idx == PAGE_BITS'(i));
    assign tbl_d[i] = hit ? wr_code : tbl_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl_q[i] <= RST_CODE;
      else        tbl_q[i] <= tbl_d[i];
    end
  end

  assign rd_code = tbl_q[rd_idx];
  assign lk_code = tbl_q[lk_idx];
endmodule

// File: rtl/cbc_dpram.sv
module cbc_dpram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_idx,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_idx,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic [DW-1:0] a_rd_q, a_rd_d, b_rd_q, b_rd_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic wa, wb;
    assign wa       = a_en && a_we && (a_idx == AW'(i));
    assign wb       = b_en && b_we && (b_idx == AW'(i)) && !wa;
    assign mem_d[i] = wa ? a_wdata : (wb ? b_wdata : mem_q[i]);
  end

  always_ff @(posedge clk) mem_q <= mem_d;

  always_comb begin
    a_rd_d = (a_en && !a_we) ? mem_q[a_idx] : a_rd_q;
    b_rd_d = (b_en && !b_we) ? mem_q[b_idx] : b_rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rd_q <= '0;
      b_rd_q <= '0;
    end else begin
      a_rd_q <= a_rd_d;
      b_rd_q <= b_rd_d;
    end
  end

  assign a_rdata = a_rd_q;
  assign b_rdata = b_rd_q;
endmodule

// File: rtl/cbc_spram.sv
module cbc_spram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic [DW-1:0] rd_q, rd_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem_d[i] = (en && we && (idx == AW'(i))) ? wdata : mem_q[i];
  end

  always_ff @(posedge clk) mem_q <= mem_d;

  assign rd_d = (en && !we) ? mem_q[idx] : rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/cbc_boot_ctrl.sv
module cbc_boot_ctrl
  import cbc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 6,
  parameter int SH_AW     = 6,
  parameter int PR_AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_sel,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  output logic              g_rst_n,
  input  logic              g_req,
  input  logic              g_we,
  input  logic [ADDR_W-1:0] g_addr,
  input  logic [DATA_W-1:0] g_wdata,
  output logic [DATA_W-1:0] g_rdata,
  output logic              g_ack,
  output logic              g_berr
);
  localparam int WORD_LSB = 2;
  localparam int PAD_W    = DATA_W - 2;

  // reset: asynchronous assert, synchronous release
  logic rs_meta_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      srst_n    <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      srst_n    <= rs_meta_q;
    end
  end

  // host side decode
  hreg_e h_reg;
  logic  h_wr, h_rd, tbl_wr_try, tbl_wr_ok, tbl_wr_bad, ctrl_wr;
  assign h_reg      = hreg_e'(h_addr[ADDR_W-1 -: 2]);
  assign h_wr       = h_sel && h_we;
  assign h_rd       = h_sel && !h_we;
  assign tbl_wr_try = h_wr && (h_reg == HR_TABLE);
  assign tbl_wr_ok  = tbl_wr_try && hold_q;
  assign tbl_wr_bad = tbl_wr_try && !hold_q;
  assign ctrl_wr    = h_wr && (h_reg == HR_CTRL);

  // control state
  logic hold_q, hold_d, err_q, err_d;
  always_comb begin
    hold_d = ctrl_wr ? h_wdata[0] : hold_q;
    if (tbl_wr_bad)                  err_d = 1'b1;
    else if (ctrl_wr && h_wdata[1])  err_d = 1'b0;
    else                             err_d = err_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      hold_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      err_q  <= err_d;
    end
  end

  assign g_rst_n = !hold_q;

  // decode table
  tgt_e rd_code, lk_code;
  logic [PAGE_BITS-1:0] g_page;
  assign g_page = g_addr[ADDR_W-1 -: PAGE_BITS];

  cbc_decode_table #(.PAGE_BITS(PAGE_BITS)) u_table (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (tbl_wr_ok),
    .wr_idx  (h_addr[WORD_LSB +: PAGE_BITS]),
    .wr_code (tgt_e'(h_wdata[1:0])),
    .rd_idx  (h_addr[WORD_LSB +: PAGE_BITS]),
    .rd_code (rd_code),
    .lk_idx  (g_page),
    .lk_code (lk_code)
  );

  // guest side decode, combinational through the table
  logic g_live, g_to_priv, g_to_sh, g_bad;
  assign g_live    = g_req && !hold_q;
  assign g_to_priv = g_live && (lk_code == TGT_PRIV);
  assign g_to_sh   = g_live && (lk_code == TGT_SHARED);
  assign g_bad     = g_live && ((lk_code == TGT_NONE) || (lk_code == TGT_RSVD));

  // memories
  logic [DATA_W-1:0] sh_a_rdata, sh_b_rdata, pr_rdata;

  cbc_dpram #(.AW(SH_AW), .DW(DATA_W)) u_shared (
    .clk     (clk),
    .rst_n   (srst_n),
    .a_en    (h_sel && (h_reg == HR_SHARED)),
    .a_we    (h_we),
    .a_idx   (h_addr[WORD_LSB +: SH_AW]),
    .a_wdata (h_wdata),
    .a_rdata (sh_a_rdata),
    .b_en    (g_to_sh),
    .b_we    (g_we),
    .b_idx   (g_addr[WORD_LSB +: SH_AW]),
    .b_wdata (g_wdata),
    .b_rdata (sh_b_rdata)
  );

  cbc_spram #(.AW(PR_AW), .DW(DATA_W)) u_private (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (g_to_priv),
    .we    (g_we),
    .idx   (g_addr[WORD_LSB +: PR_AW]),
    .wdata (g_wdata),
    .rdata (pr_rdata)
  );

  // response and read-path registers
  logic  ack_q, ack_d, berr_q, berr_d, gsrc_q, gsrc_d, grd_q, grd_d;
  hreg_e rsel_q, rsel_d;
  logic [DATA_W-1:0] loc_q, loc_d;

  always_comb begin
    ack_d  = g_to_priv || g_to_sh;
    berr_d = g_bad;
    gsrc_d = g_live ? g_to_priv : gsrc_q;
    grd_d  = g_live && !g_we;
    rsel_d = h_rd ? h_reg : rsel_q;
    loc_d  = loc_q;
    if (h_rd) begin
      case (h_reg)
        HR_TABLE: loc_d = {{PAD_W{1'b0}}, rd_code};
        HR_CTRL:  loc_d = {{PAD_W{1'b0}}, err_q, hold_q};
        default:  loc_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ack_q  <= 1'b0;
      berr_q <= 1'b0;
      gsrc_q <= 1'b0;
      grd_q  <= 1'b0;
      rsel_q <= HR_NONE;
      loc_q  <= '0;
    end else begin
      ack_q  <= ack_d;
      berr_q <= berr_d;
      gsrc_q <= gsrc_d;
      grd_q  <= grd_d;
      rsel_q <= rsel_d;
      loc_q  <= loc_d;
    end
  end

  assign g_ack   = ack_q;
  assign g_berr  = berr_q;
  assign g_rdata = (ack_q && grd_q) ? (gsrc_q ? pr_rdata : sh_b_rdata) : '0;
  assign h_rdata = (rsel_q == HR_SHARED) ? sh_a_rdata : loc_q;

  logic unused_bits;
  assign unused_bits = ^{h_addr, g_addr, h_wdata};
endmodule

// File: rtl/cbc_boot_ctrl_chk.sv
module cbc_boot_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              srst_n,
  input logic              h_sel,
  input logic              h_we,
  input logic [1:0]        h_top,
  input logic              g_req,
  input logic              g_rst_n,
  input logic              g_ack,
  input logic              g_berr,
  input logic [DATA_W-1:0] g_rdata,
  input logic              err_q,
  input logic [1:0]        lk_code
);
  AST_ACK_BERR_EXCL: assert property (@(posedge clk) disable iff (!srst_n)
    !(g_ack && g_berr)); // R5

  AST_RESP_NEEDS_LIVE_REQ: assert property (@(posedge clk) disable iff (!srst_n)
    (g_ack || g_berr) |-> $past(g_req && g_rst_n)); // R4

  AST_HOLD_NEEDS_CTRL_WRITE: assert property (@(posedge clk) disable iff (!srst_n)
    (!g_rst_n && !(h_sel && h_we && h_top == 2'b11)) |=> !g_rst_n); // R4

  AST_BERR_NO_DATA: assert property (@(posedge clk) disable iff (!srst_n)
    g_berr |-> (g_rdata == '0)); // R6

  AST_BAD_PAGE_BERR: assert property (@(posedge clk) disable iff (!srst_n)
    (g_req && g_rst_n && (lk_code == 2'd0 || lk_code == 2'd3)) |=> g_berr); // R6

  AST_TBL_LOCK_ERR: assert property (@(posedge clk) disable iff (!srst_n)
    (h_sel && h_we && h_top == 2'b10 && g_rst_n) |=> err_q); // R7
endmodule

bind cbc_boot_ctrl cbc_boot_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .srst_n  (srst_n),
  .h_sel   (h_sel),
  .h_we    (h_we),
  .h_top   (h_addr[ADDR_W-1 -: 2]),
  .g_req   (g_req),
  .g_rst_n (g_rst_n),
  .g_ack   (g_ack),
  .g_berr  (g_berr),
  .g_rdata (g_rdata),
  .err_q   (err_q),
  .lk_code (lk_code)
);

// File: tb/cbc_boot_ctrl_tb.sv
module cbc_boot_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        h_sel, h_we;
  logic [23:0] h_addr;
  logic [31:0] h_wdata, h_rdata;
  logic        g_rst_n;
  logic        g_req, g_we;
  logic [23:0] g_addr;
  logic [31:0] g_wdata, g_rdata;
  logic        g_ack, g_berr;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  localparam logic [23:0] TBL  = 24'h800000;
  localparam logic [23:0] CTRL = 24'hC00000;

  always #4 clk = ~clk;

  cbc_boot_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .h_sel(h_sel), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .g_rst_n(g_rst_n),
    .g_req(g_req), .g_we(g_we), .g_addr(g_addr), .g_wdata(g_wdata),
    .g_rdata(g_rdata), .g_ack(g_ack), .g_berr(g_berr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [23:0] a, input logic [31:0] d);
    @(negedge clk);
    h_sel = 1'b1; h_we = 1'b1; h_addr = a; h_wdata = d;
    @(posedge clk);
    @(negedge clk);
    h_sel = 1'b0; h_we = 1'b0;
  endtask

  task automatic host_rd(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    h_sel = 1'b1; h_we = 1'b0; h_addr = a;
    @(posedge clk);
    @(negedge clk);
    h_sel = 1'b0;
    d = h_rdata;
  endtask

  task automatic guest_op(input logic we, input logic [23:0] a, input logic [31:0] d,
                          output logic ack, output logic berr, output logic [31:0] rd);
    @(negedge clk);
    g_req = 1'b1; g_we = we; g_addr = a; g_wdata = d;
    @(posedge clk);
    @(negedge clk);
    g_req = 1'b0; g_we = 1'b0;
    ack = g_ack; berr = g_berr; rd = g_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 g_rst_n low", {31'd0, g_rst_n}, 32'd0);
    host_rd(CTRL, d);
    chk("R1 control word", d, 32'h1);
    host_rd(TBL, d);
    chk("R2 entry 0", d, 32'd2);
    host_rd(TBL + 24'd20, d);
    chk("R2 entry 5", d, 32'd0);
    host_rd(TBL + 24'd252, d);
    chk("R2 entry 63", d, 32'd0);
  endtask

  task automatic t_host_shared();
    logic [31:0] d;
    host_wr(24'h000000, 32'hB007_0000);
    host_wr(24'h000004, 32'hB007_0001);
    host_wr(24'h0000FC, 32'hCAFE_003F);
    host_rd(24'h000004, d);
    chk("R3 word 1", d, 32'hB007_0001);
    host_rd(24'h0000FC, d);
    chk("R3 last word", d, 32'hCAFE_003F);
    host_rd(24'h000000, d);
    chk("R3 word 0", d, 32'hB007_0000);
  endtask

  task automatic t_held_guest();
    logic ack, berr; logic [31:0] rd, d;
    host_wr(24'h00000C, 32'h1111_1111);
    guest_op(1'b1, 24'h00000C, 32'hDEAD_DEAD, ack, berr, rd);
    chk("R4 held no ack/berr", {30'd0, ack, berr}, 32'd0);
    host_rd(24'h00000C, d);
    chk("R4 held write dropped", d, 32'h1111_1111);
  endtask

  task automatic t_setup_and_release();
    host_wr(TBL + 24'd4,  32'd1);   // page 1 private
    host_wr(TBL + 24'd8,  32'd2);   // page 2 shared
    host_wr(TBL + 24'd28, 32'd3);   // page 7 reserved
    host_wr(CTRL, 32'd0);
    chk("R4 released", {31'd0, g_rst_n}, 32'd1);
  endtask

  task automatic t_guest_decode();
    logic ack, berr; logic [31:0] rd, d;
    guest_op(1'b0, 24'h000004, 32'd0, ack, berr, rd);
    chk("R5 shared read ack", {31'd0, ack}, 32'd1);
    chk("R5 shared read data", rd, 32'hB007_0001);
    guest_op(1'b1, 24'h080008, 32'h5E5E_0002, ack, berr, rd);
    chk("R5 shared write ack", {31'd0, ack}, 32'd1);
    host_rd(24'h000008, d);
    chk("R5 exchange visible to host", d, 32'h5E5E_0002);
    guest_op(1'b1, 24'h040000, 32'hF00D_0000, ack, berr, rd);
    guest_op(1'b0, 24'h040000, 32'd0, ack, berr, rd);
    chk("R5 private read data", rd, 32'hF00D_0000);
  endtask

  task automatic t_unmapped();
    logic ack, berr; logic [31:0] rd;
    guest_op(1'b0, 24'h140000, 32'd0, ack, berr, rd);
    chk("R6 code 0 berr/ack", {30'd0, ack, berr}, 32'd1);
    chk("R6 code 0 data", rd, 32'd0);
    @(negedge clk);
    chk("R6 berr one cycle", {31'd0, g_berr}, 32'd0);
    guest_op(1'b0, 24'h1C0000, 32'd0, ack, berr, rd);
    chk("R6 code 3 berr/ack", {30'd0, ack, berr}, 32'd1);
  endtask

  task automatic t_lock();
    logic ack, berr; logic [31:0] rd, d;
    host_wr(TBL, 32'd1);
    host_rd(CTRL, d);
    chk("R7 error set", d, 32'h2);
    host_rd(TBL, d);
    chk("R7 entry 0 unchanged", d, 32'd2);
    guest_op(1'b0, 24'h000000, 32'd0, ack, berr, rd);
    chk("R7 page 0 still shared", rd, 32'hB007_0000);
    host_wr(CTRL, 32'h2);
    host_rd(CTRL, d);
    chk("R7 error cleared", d, 32'h0);
  endtask

  task automatic t_remap();
    logic ack, berr; logic [31:0] rd, d;
    guest_op(1'b1, 24'h040000, 32'hC0DE_0000, ack, berr, rd);
    host_wr(CTRL, 32'h1);
    chk("R9 re-held", {31'd0, g_rst_n}, 32'd0);
    host_rd(TBL + 24'd4, d);
    chk("R9 entry 1 kept", d, 32'd1);
    host_rd(TBL + 24'd8, d);
    chk("R9 entry 2 kept", d, 32'd2);
    host_wr(TBL, 32'd1);
    host_wr(CTRL, 32'h0);
    guest_op(1'b0, 24'h000000, 32'd0, ack, berr, rd);
    chk("R8 page 0 from private", rd, 32'hC0DE_0000);
    chk("R8 ack", {31'd0, ack}, 32'd1);
  endtask

  task automatic t_conflict();
    logic [31:0] d;
    // write/write on word 10
    @(negedge clk);
    h_sel = 1'b1; h_we = 1'b1; h_addr = 24'h000028; h_wdata = 32'hAAAA_000A;
    g_req = 1'b1; g_we = 1'b1; g_addr = 24'h080028; g_wdata = 32'hBBBB_000A;
    @(posedge clk);
    @(negedge clk);
    h_sel = 1'b0; h_we = 1'b0; g_req = 1'b0; g_we = 1'b0;
    host_rd(24'h000028, d);
    chk("R10 host write wins", d, 32'hAAAA_000A);
    // read/write on word 9
    host_wr(24'h000024, 32'h0000_01D0);
    @(negedge clk);
    h_sel = 1'b1; h_we = 1'b1; h_addr = 24'h000024; h_wdata = 32'h0000_0EE0;
    g_req = 1'b1; g_we = 1'b0; g_addr = 24'h080024;
    @(posedge clk);
    @(negedge clk);
    h_sel = 1'b0; h_we = 1'b0;
    chk("R10 same-cycle read old", g_rdata, 32'h0000_01D0);
    @(posedge clk);
    @(negedge clk);
    g_req = 1'b0;
    chk("R10 next read new", g_rdata, 32'h0000_0EE0);
  endtask

  initial begin
    rst_n = 1'b0;
    h_sel = 1'b0; h_we = 1'b0; h_addr = '0; h_wdata = '0;
    g_req = 1'b0; g_we = 1'b0; g_addr = '0; g_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_host_shared();
    t_held_guest();
    t_setup_and_release();
    t_guest_decode();
    t_unmapped();
    t_lock();
    t_remap();
    t_conflict();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule